// File: doc/BRIEF.md
# Desaturation Fault Detector with Blanking

This block supervises one power switch against short circuit. It sits between the control logic's gate command and the gate stage. It takes a one-bit flag from an external comparator; the flag is high when the on-state switch voltage is above its reference. Right after each turn-on, the switch voltage has not yet collapsed. For that reason the flag is ignored for a programmable number of clock cycles that starts at the turn-on edge.

Once blanking is over, the flag must stay high for the same number of consecutive cycles before a fault is declared. This rejects short spurious assertions. A declared fault removes the gate drive in the same cycle and emits a one-cycle fault pulse toward the central fault memory. The switch stays off until the command is withdrawn and issued again. The fault memory can also hold the gate output low through a dedicated input.

Top module: `desat_guard`

## Requirements
- R1: While rst_ni is low, gate_o and fault_o are both 0.
- R2: With no fault and fault_hold_i low, gate_o follows gate_cmd_i one clock later. It goes high in the cycle after the first edge that samples the command high, and low in the cycle after the first edge that samples it low.
- R3: Let L be blank_len_i captured at the turn-on edge, with 0 taken as 1. For the L clock edges that follow the turn-on edge, sat_flag_i has no effect. Changing blank_len_i while the command stays high has no effect until the next turn-on.
- R4: After blanking, a fault is declared only when sat_flag_i is sampled high on L consecutive edges. A single low sample restarts the count.
- R5: A declared fault drives fault_o high for exactly one cycle. In that same cycle gate_o goes low, and it stays low while gate_cmd_i remains high. A later low-then-high command starts a new on period.
- R6: If gate_cmd_i is sampled low during blanking, no fault is raised and the blanking count is discarded. The next turn-on runs a full new window.
- R7: While fault_hold_i is high, gate_o is 0 in the same cycle, without a clock edge. Fault detection continues underneath.
- R8: A blank_len_i of 0 at turn-on behaves as 1. This gives one cycle of blanking and a one-sample filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_cmd_i | input | 1 | Gate command from the control logic, 1 = on |
| sat_flag_i | input | 1 | Comparator result, 1 = switch voltage above reference |
| blank_len_i | input | CW (8) | Blanking and filter length in clock cycles |
| fault_hold_i | input | 1 | From the fault memory, 1 = force gate off |
| gate_o | output | 1 | Filtered gate command to the gate stage |
| fault_o | output | 1 | One-cycle pulse on a detected desaturation |

## Verification
Some rules are checked on every cycle: the fault pulse lasts one cycle, the gate is off whenever a fault pulses or the hold input is high, the gate is off one cycle after a low command, no fault follows a blanking cycle, and both counters stay below the captured length. Other behaviour can only be shown by the bench scenarios. That covers the exact turn-on cycle and the fault cycle for a given length, the capture of the length at turn-on, the restart of the filter after a gap, the full new window after an aborted turn-on, and the off state after a fault that persists until the command cycles.

// File: rtl/desat_pkg.sv
package desat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_WATCH = 2'd2,
    ST_TRIP  = 2'd3
  } desat_st_e;
endpackage

// File: rtl/desat_blank_timer.sv
module desat_blank_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o,
  output logic [CW-1:0] len_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, len_q;

  assign done_o = run_i && (cnt_q == len_q - ONE);
  assign len_o  = len_q;

  // length is captured at turn-on, zero promoted to one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= ONE;
      cnt_q <= '0;
    end else if (start_i) begin
      len_q <= (len_i == '0) ? ONE : len_i;
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      cnt_q <= '0;
    end
  end

  p_blank_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_q));
  p_len_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q != '0);
endmodule

// File: rtl/desat_glitch_filter.sv
module desat_glitch_filter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          flag_i,
  input  logic [CW-1:0] len_i,
  output logic          hit_o
);
  logic [CW-1:0] fcnt_q;
  logic [CW:0]   fcnt_inc;

  assign fcnt_inc = {1'b0, fcnt_q} + (CW+1)'(1);
  assign hit_o    = en_i && flag_i && (fcnt_inc >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     fcnt_q <= '0;
    else if (!en_i || !flag_i || hit_o) fcnt_q <= '0;
    else                             fcnt_q <= fcnt_inc[CW-1:0];
  end

  p_filter_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (fcnt_q < len_i));
  p_gap_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |=> (fcnt_q == '0));
endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import desat_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_cmd_i,
  input  logic          sat_flag_i,
  input  logic [CW-1:0] blank_len_i,
  input  logic          fault_hold_i,
  output logic          gate_o,
  output logic          fault_o
);
  desat_st_e     st_q, st_d;
  logic          start, run, watch, blank_done, hit, fault_q;
  logic [CW-1:0] len_cap;

  assign start = gate_cmd_i && (st_q == ST_IDLE);
  assign run   = gate_cmd_i && (st_q == ST_BLANK);
  assign watch = gate_cmd_i && (st_q == ST_WATCH);

  desat_blank_timer #(.CW(CW)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (run),
    .len_i  (blank_len_i),
    .done_o (blank_done),
    .len_o  (len_cap)
  );

  desat_glitch_filter #(.CW(CW)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (watch),
    .flag_i (sat_flag_i),
    .len_i  (len_cap),
    .hit_o  (hit)
  );

  always_comb begin
    st_d = st_q;
    if (!gate_cmd_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_BLANK;
        ST_BLANK: if (blank_done) st_d = ST_WATCH;
        ST_WATCH: if (hit) st_d = ST_TRIP;
        default:  st_d = ST_TRIP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= hit;
    end
  end

  // hold from the fault memory acts without a clock edge
  assign gate_o  = ((st_q == ST_BLANK) || (st_q == ST_WATCH)) && !fault_hold_i;
  assign fault_o = fault_q;

  p_fault_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  p_fault_kills_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !gate_o);
  p_cmd_low_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_cmd_i |=> !gate_o);
  p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_hold_i |-> !gate_o);
  p_blank_no_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BLANK) |=> !fault_o);
  p_abort_no_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_cmd_i |=> !fault_o);
endmodule

// File: tb/sim_desat_guard.sv
`timescale 1ns/1ps
module sim_desat_guard;
  localparam int CW = 8;

  typedef struct {
    logic  gate;
    logic  fault;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd = 1'b0, flag = 1'b0, hold = 1'b0;
  logic [CW-1:0] blen = '0;
  logic          gate_o, fault_o;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_tag = "R1";
  exp_t  q[$];

  always #2.5 clk = ~clk;

  desat_guard #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gate_cmd_i(cmd), .sat_flag_i(flag),
    .blank_len_i(blen), .fault_hold_i(hold), .gate_o(gate_o), .fault_o(fault_o)
  );

  // reference model from the requirements; 0 idle 1 blank 2 watch 3 tripped
  int m_st = 0, m_b = 0, m_f = 0, m_len = 1;
  logic m_fault = 1'b0;
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_st = 0; m_b = 0; m_f = 0; m_fault = 1'b0;
    end else begin
      m_fault = 1'b0;
      if (!cmd) begin
        m_st = 0; m_b = 0; m_f = 0;
      end else begin
        case (m_st)
          0: begin m_len = (blen == 0) ? 1 : int'(blen); m_b = 0; m_st = 1; end
          1: if (m_b == m_len - 1) begin m_st = 2; m_f = 0; end else m_b++;
          2: if (flag) begin
               if (m_f + 1 >= m_len) begin m_st = 3; m_fault = 1'b1; m_f = 0; end
               else m_f++;
             end else m_f = 0;
          default: m_st = 3;
        endcase
      end
      e.gate = (m_st == 1) || (m_st == 2);
      e.fault = m_fault;
      e.tag = cur_tag;
      q.push_back(e);
    end
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic eg;
      e = q.pop_front();
      eg = e.gate & ~hold;
      checks++;
      if (gate_o !== eg) begin
        errors++;
        $display("FAIL %s gate_o actual %0b expected %0b at %0t", e.tag, gate_o, eg, $time);
      end
      checks++;
      if (fault_o !== e.fault) begin
        errors++;
        $display("FAIL %s fault_o actual %0b expected %0b at %0t", e.tag, fault_o, e.fault, $time);
      end
    end
  end

  task automatic step(input logic c, input logic f, input int l, input logic h, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd = c; flag = f; blen = CW'(l); hold = h;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 1, 3, 0, 3);           // stimulus under reset must not matter
    #1;
    checks++;
    if (gate_o !== 1'b0 || fault_o !== 1'b0) begin  // R1
      errors++;
      $display("FAIL R1 reset outputs actual %0b%0b expected 00", gate_o, fault_o);
    end
    step(0, 0, 4, 0, 2);
    rst_n = 1'b1;

    cur_tag = "R2";
    step(1, 0, 4, 0, 15); step(0, 0, 4, 0, 5);
    step(1, 1, 4, 0, 1);  step(0, 1, 4, 0, 4);

    cur_tag = "R3";  // flag during blanking, length changed mid-period
    step(1, 1, 5, 0, 3); step(1, 0, 30, 0, 4);
    step(1, 1, 30, 0, 8); step(0, 0, 5, 0, 4);

    cur_tag = "R4";
    step(1, 0, 4, 0, 6); step(1, 1, 4, 0, 3); step(1, 0, 4, 0, 2);
    step(1, 1, 4, 0, 2); step(1, 0, 4, 0, 1); step(1, 1, 4, 0, 12);
    step(0, 0, 4, 0, 3);

    cur_tag = "R5";
    step(1, 1, 3, 0, 14); step(0, 1, 3, 0, 2);
    step(1, 0, 3, 0, 8);  step(0, 0, 3, 0, 3);

    cur_tag = "R6";
    step(1, 1, 6, 0, 3); step(0, 1, 6, 0, 1);
    step(1, 1, 6, 0, 9); step(1, 1, 6, 0, 6); step(0, 0, 6, 0, 3);

    cur_tag = "R7";
    step(1, 0, 4, 0, 3); step(1, 0, 4, 1, 4);
    step(1, 1, 4, 1, 10); step(1, 1, 4, 0, 2); step(0, 0, 4, 0, 3);

    cur_tag = "R8";
    step(1, 1, 0, 0, 6); step(0, 0, 0, 0, 2);
    step(1, 0, 0, 0, 3); step(1, 1, 0, 0, 3); step(0, 0, 0, 0, 3);

    repeat (4) @(negedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule